// File: doc/BRIEF.md
# Multi-Mode Operand Resolver

This block finds the operand of an accumulator-style instruction under seven addressing modes. A caller presents a 3-bit mode code, an 8-bit address field and a register selector, then pulses `start`. The block works out the effective address and fetches the operand. It makes as many memory reads as the mode needs: none, one, or two chained reads. When it finishes, it raises `done` for one cycle with the operand and the effective address. A mode code outside the seven legal ones raises an error flag together with `done`.

The block holds a small register file of `NREG` entries, 8 bits each, loaded through a write port. The highest-numbered entry is the stack pointer. Memory is a single-port synchronous read interface. The memory samples `mem_req` and `mem_addr` at a clock edge and presents `mem_rdata` during the following cycle. The block spends one request cycle and one capture cycle on each read.

Top module: `ea_resolver`

## Requirements
- R1: Mode 0 (immediate) returns the address field as both operand and effective address. It makes no memory read, and `done` rises in the cycle right after the start edge.
- R2: Mode 1 (direct) uses the address field as the effective address and makes exactly one read there. The operand is the data that read returns, and `done` comes three cycles after the start edge.
- R3: Mode 2 (indirect) reads a pointer at the address field, then reads the operand at that pointer. It makes exactly two reads, the pointer is reported as the effective address, and `done` comes five cycles after the start edge.
- R4: Mode 3 (register) returns the selected register as operand and the zero-extended selector as effective address. It makes no memory read, and `done` comes one cycle after the start edge.
- R5: Mode 4 (register indirect) uses the selected register's content as the effective address and makes one read there. `done` comes three cycles after the start edge.
- R6: Mode 5 (displacement) uses the address field plus the selected register, wrapped modulo 256, as the effective address and makes one read there. `done` comes three cycles after the start edge.
- R7: Mode 6 (stack) uses the stack pointer (register `NREG-1`) as the effective address and makes one read there. The selector has no effect in this mode.
- R8: Mode 7 raises `mode_err` together with `done` one cycle after the start edge, makes no read, and reports operand and effective address as 0. At every other time `mode_err` is low.
- R9: Each read drives `mem_req` high for exactly one cycle. `mem_addr` stays unchanged into the capture cycle that follows, and `mem_rdata` is taken in that capture cycle.
- R10: `done` lasts one cycle for each resolution. A `start` that arrives while a resolution is in progress is ignored and changes neither the result nor the timing.
- R11: A register write through the write port takes effect at the clock edge. A start sampled at that same edge reads the value the register held before the write.
- R12: After reset, `done`, `mode_err` and `mem_req` are low, operand and effective address are 0, and every register, the stack pointer included, is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a resolution (taken only when idle) |
| mode | input | 3 | Addressing mode code 0..7 |
| addr_field | input | 8 | Address field of the instruction |
| reg_sel | input | 2 | Register selector |
| reg_we | input | 1 | Register write enable |
| reg_wsel | input | 2 | Register write index (3 is the stack pointer) |
| reg_wdata | input | 8 | Register write data |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 8 | Memory read address |
| mem_rdata | input | 8 | Memory read data, valid the cycle after a request |
| operand | output | 8 | Resolved operand, held until the next completion |
| eff_addr | output | 8 | Effective address, held until the next completion |
| done | output | 1 | One-cycle completion strobe |
| mode_err | output | 1 | Illegal mode indication, valid with done |

## Verification
A behavioural reference model in the bench predicts the completion cycle, the read count, the operand and the effective address for every mode. It compares these with the ports on every clock. Several register contents and address fields are used. A displacement that wraps past 255 and one that does not separate a correct 8-bit wrap from a widened sum. An indirect resolution interrupted by a stray start separates a busy-ignoring controller from one that restarts. A register write issued in the same cycle as a start separates read-before-write from write-through. A stack resolution with a non-stack selector shows that the selector is ignored in that mode.

// File: rtl/ea_pkg.sv
package ea_pkg;

    typedef enum logic [2:0] {
        MD_IMM  = 3'd0,
        MD_DIR  = 3'd1,
        MD_IND  = 3'd2,
        MD_REG  = 3'd3,
        MD_RIND = 3'd4,
        MD_DISP = 3'd5,
        MD_STK  = 3'd6,
        MD_BAD  = 3'd7
    } mode_e;

    // How the controller must finish a resolution
    typedef enum logic [1:0] {
        K_NOW   = 2'd0,
        K_READ  = 2'd1,
        K_CHAIN = 2'd2,
        K_BAD   = 2'd3
    } kind_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_CAP  = 2'd2
    } state_e;

endpackage

// File: rtl/ea_regfile.sv
module ea_regfile #(
    parameter int DW   = 8,
    parameter int NREG = 4,
    localparam int SELW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [SELW-1:0] wsel,
    input  logic [DW-1:0]   wdata,
    input  logic [SELW-1:0] rsel,
    output logic [DW-1:0]   rdata,
    output logic [DW-1:0]   sp
);

    logic [DW-1:0] regs_q [NREG];

    for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
        logic [DW-1:0] reg_d;
        always_comb begin
            reg_d = regs_q[gi];
            if (we && (wsel == SELW'(gi))) begin
                reg_d = wdata;
            end
        end
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs_q[gi] <= '0;
            end else begin
                regs_q[gi] <= reg_d;
            end
        end
    end

    assign rdata = regs_q[rsel];
    assign sp    = regs_q[NREG-1];

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (regs_q[$past(wsel)] == $past(wdata))) else $error("write lost"); // R11

endmodule

// File: rtl/ea_seed.sv
module ea_seed
    import ea_pkg::*;
#(
    parameter int DW   = 8,
    parameter int SELW = 2
) (
    input  logic [2:0]      mode,
    input  logic [DW-1:0]   field,
    input  logic [SELW-1:0] sel,
    input  logic [DW-1:0]   reg_val,
    input  logic [DW-1:0]   sp,
    output kind_e           kind,
    output logic [DW-1:0]   seed_addr,
    output logic [DW-1:0]   seed_val
);

    logic [DW-1:0] sel_ext;
    logic [DW-1:0] disp_sum;

    assign sel_ext  = {{(DW-SELW){1'b0}}, sel};
    assign disp_sum = field + reg_val;  // wraps at DW bits

    always_comb begin
        kind      = K_BAD;
        seed_addr = '0;
        seed_val  = '0;
        case (mode_e'(mode))
            MD_IMM: begin
                kind      = K_NOW;
                seed_addr = field;
                seed_val  = field;
            end
            MD_DIR: begin
                kind      = K_READ;
                seed_addr = field;
            end
            MD_IND: begin
                kind      = K_CHAIN;
                seed_addr = field;
            end
            MD_REG: begin
                kind      = K_NOW;
                seed_addr = sel_ext;
                seed_val  = reg_val;
            end
            MD_RIND: begin
                kind      = K_READ;
                seed_addr = reg_val;
            end
            MD_DISP: begin
                kind      = K_READ;
                seed_addr = disp_sum;
            end
            MD_STK: begin
                kind      = K_READ;
                seed_addr = sp;
            end
            default: begin
                kind      = K_BAD;
            end
        endcase
    end

endmodule

// File: rtl/ea_ctrl.sv
module ea_ctrl
    import ea_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  kind_e         kind,
    input  logic [DW-1:0] seed_addr,
    input  logic [DW-1:0] seed_val,
    output logic          mem_req,
    output logic [DW-1:0] mem_addr,
    input  logic [DW-1:0] mem_rdata,
    output logic [DW-1:0] operand,
    output logic [DW-1:0] eff_addr,
    output logic          done,
    output logic          err,
    output logic          idle
);

    typedef struct packed {
        state_e        state;
        logic          chain;
        logic [DW-1:0] addr;
        logic [DW-1:0] operand;
        logic [DW-1:0] ea;
        logic          done;
        logic          err;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.err  = 1'b0;
        case (st_q.state)
            ST_IDLE: begin
                if (start) begin
                    case (kind)
                        K_NOW: begin
                            st_d.operand = seed_val;
                            st_d.ea      = seed_addr;
                            st_d.done    = 1'b1;
                        end
                        K_READ: begin
                            st_d.addr  = seed_addr;
                            st_d.chain = 1'b0;
                            st_d.state = ST_REQ;
                        end
                        K_CHAIN: begin
                            st_d.addr  = seed_addr;
                            st_d.chain = 1'b1;
                            st_d.state = ST_REQ;
                        end
                        default: begin
                            st_d.operand = '0;
                            st_d.ea      = '0;
                            st_d.done    = 1'b1;
                            st_d.err     = 1'b1;
                        end
                    endcase
                end
            end
            ST_REQ: begin
                st_d.state = ST_CAP;
            end
            ST_CAP: begin
                if (st_q.chain) begin
                    st_d.addr  = mem_rdata;
                    st_d.chain = 1'b0;
                    st_d.state = ST_REQ;
                end else begin
                    st_d.operand = mem_rdata;
                    st_d.ea      = st_q.addr;
                    st_d.done    = 1'b1;
                    st_d.state   = ST_IDLE;
                end
            end
            default: begin
                st_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{state: ST_IDLE, chain: 1'b0, addr: '0, operand: '0,
                      ea: '0, done: 1'b0, err: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_req  = (st_q.state == ST_REQ);
    assign mem_addr = st_q.addr;
    assign operand  = st_q.operand;
    assign eff_addr = st_q.ea;
    assign done     = st_q.done;
    assign err      = st_q.err;
    assign idle     = (st_q.state == ST_IDLE);

    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req) else $error("request longer than a cycle"); // R9
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> $stable(mem_addr)) else $error("address moved before capture"); // R9
    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done) else $error("error without done"); // R8
    AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && !mem_req) |=> (mem_req || idle)) else $error("busy path stalled"); // R10

endmodule

// File: rtl/ea_resolver.sv
module ea_resolver
    import ea_pkg::*;
#(
    parameter int DW   = 8,
    parameter int NREG = 4,
    localparam int SELW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [2:0]      mode,
    input  logic [DW-1:0]   addr_field,
    input  logic [SELW-1:0] reg_sel,
    input  logic            reg_we,
    input  logic [SELW-1:0] reg_wsel,
    input  logic [DW-1:0]   reg_wdata,
    output logic            mem_req,
    output logic [DW-1:0]   mem_addr,
    input  logic [DW-1:0]   mem_rdata,
    output logic [DW-1:0]   operand,
    output logic [DW-1:0]   eff_addr,
    output logic            done,
    output logic            mode_err
);

    logic [DW-1:0] reg_val;
    logic [DW-1:0] sp_val;
    kind_e         kind;
    logic [DW-1:0] seed_addr;
    logic [DW-1:0] seed_val;
    logic          idle;

    ea_regfile #(.DW(DW), .NREG(NREG)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .wsel  (reg_wsel),
        .wdata (reg_wdata),
        .rsel  (reg_sel),
        .rdata (reg_val),
        .sp    (sp_val)
    );

    ea_seed #(.DW(DW), .SELW(SELW)) u_seed (
        .mode      (mode),
        .field     (addr_field),
        .sel       (reg_sel),
        .reg_val   (reg_val),
        .sp        (sp_val),
        .kind      (kind),
        .seed_addr (seed_addr),
        .seed_val  (seed_val)
    );

    ea_ctrl #(.DW(DW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .kind      (kind),
        .seed_addr (seed_addr),
        .seed_val  (seed_val),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .operand   (operand),
        .eff_addr  (eff_addr),
        .done      (done),
        .err       (mode_err),
        .idle      (idle)
    );

    AST_IMM_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && start && mode == 3'd0) |=> (done && !mem_req && operand == $past(addr_field)))
        else $error("immediate mode misbehaved"); // R1
    AST_BAD_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && start && mode == 3'd7) |=> (done && mode_err && !mem_req))
        else $error("illegal mode not flagged"); // R8
    AST_DIRECT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && start && mode == 3'd1) |=> (mem_req && mem_addr == $past(addr_field)))
        else $error("direct read at wrong address"); // R2

endmodule

// File: tb/ea_resolver_tb.sv
`timescale 1ns/1ps
module ea_resolver_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [2:0] mode = '0;
    logic [7:0] addr_field = '0;
    logic [1:0] reg_sel = '0;
    logic       reg_we = 1'b0;
    logic [1:0] reg_wsel = '0;
    logic [7:0] reg_wdata = '0;
    logic       mem_req;
    logic [7:0] mem_addr;
    logic [7:0] mem_rdata = '0;
    logic [7:0] operand;
    logic [7:0] eff_addr;
    logic       done;
    logic       mode_err;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int rm [4];

    always #2.5 clk = ~clk;

    ea_resolver u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .addr_field(addr_field), .reg_sel(reg_sel), .reg_we(reg_we),
        .reg_wsel(reg_wsel), .reg_wdata(reg_wdata), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .operand(operand),
        .eff_addr(eff_addr), .done(done), .mode_err(mode_err)
    );

    function automatic int memf(int a);
        return (a * 29 + 71) & 255;
    endfunction

    // memory model: one-cycle read latency
    always @(posedge clk) begin
        if (mem_req) mem_rdata <= 8'(memf(int'(mem_addr)));
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr_reg(input int s, input int v);
        @(negedge clk);
        reg_we = 1'b1; reg_wsel = 2'(s); reg_wdata = 8'(v);
        @(negedge clk);
        reg_we = 1'b0;
        rm[s] = v;
    endtask

    // Resolve one operand and compare every cycle with the model.
    task automatic resolve(input int md, input int fld, input int sel,
                           input bit dowr, input int ws, input int wd,
                           input bit stray, input string req);
        int lat, nrd, e_op, e_ea, reads, p;
        bit e_err;
        e_err = 0; e_op = 0; e_ea = 0; lat = 1; nrd = 0;
        case (md)
            0: begin e_op = fld; e_ea = fld; end
            1: begin e_ea = fld; e_op = memf(fld); lat = 3; nrd = 1; end
            2: begin p = memf(fld); e_ea = p; e_op = memf(p); lat = 5; nrd = 2; end
            3: begin e_op = rm[sel]; e_ea = sel; end
            4: begin e_ea = rm[sel]; e_op = memf(e_ea); lat = 3; nrd = 1; end
            5: begin e_ea = (fld + rm[sel]) % 256; e_op = memf(e_ea); lat = 3; nrd = 1; end
            6: begin e_ea = rm[3]; e_op = memf(e_ea); lat = 3; nrd = 1; end
            default: begin e_err = 1; end
        endcase
        @(negedge clk);
        start = 1'b1; mode = 3'(md); addr_field = 8'(fld); reg_sel = 2'(sel);
        if (dowr) begin reg_we = 1'b1; reg_wsel = 2'(ws); reg_wdata = 8'(wd); end
        @(posedge clk);
        if (dowr) rm[ws] = wd;
        reads = 0;
        for (int n = 1; n <= lat + 1; n++) begin
            @(negedge clk);
            if (n == 1) begin
                start = 1'b0; reg_we = 1'b0;
                if (stray) begin start = 1'b1; mode = 3'd0; addr_field = 8'hEE; end
            end
            if (n == 2) start = 1'b0;
            if (mem_req) reads++;
            chk(done == (n == lat), {req, " done timing"}, int'(done), int'(n == lat));
            chk(mode_err == (e_err && n == lat), {req, " mode_err"}, int'(mode_err), int'(e_err && n == lat));
            if (n == lat) begin
                chk(operand == 8'(e_op), {req, " operand"}, int'(operand), e_op);
                chk(eff_addr == 8'(e_ea), {req, " eff_addr"}, int'(eff_addr), e_ea);
            end
        end
        chk(reads == nrd, {req, " read count"}, reads, nrd);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) rm[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk(!done && !mode_err && !mem_req, "R12 strobes low", int'({done, mode_err, mem_req}), 0);
        chk(operand == 0 && eff_addr == 0, "R12 outputs zero", int'({operand, eff_addr}), 0);
        resolve(3, 0, 2, 0, 0, 0, 0, "R12 register zero");
        resolve(6, 0, 1, 0, 0, 0, 0, "R12 stack pointer zero");

        resolve(0, 8'h5A, 0, 0, 0, 0, 0, "R1 immediate");
        resolve(0, 8'hFF, 3, 0, 0, 0, 0, "R1 immediate max");
        resolve(1, 8'h10, 0, 0, 0, 0, 0, "R2 direct");
        resolve(1, 8'hC3, 2, 0, 0, 0, 0, "R2 direct b");
        resolve(2, 8'h20, 0, 0, 0, 0, 0, "R3 indirect");

        wr_reg(0, 8'h40);
        wr_reg(1, 8'hF0);
        wr_reg(2, 8'h33);
        wr_reg(3, 8'h80);

        resolve(3, 0, 1, 0, 0, 0, 0, "R4 register");
        resolve(3, 8'h77, 3, 0, 0, 0, 0, "R4 register sp");
        resolve(4, 0, 0, 0, 0, 0, 0, "R5 register indirect");
        resolve(4, 0, 2, 0, 0, 0, 0, "R5 register indirect b");
        resolve(5, 8'h30, 1, 0, 0, 0, 0, "R6 displacement wrap");
        resolve(5, 8'h05, 2, 0, 0, 0, 0, "R6 displacement plain");
        resolve(6, 8'h11, 2, 0, 0, 0, 0, "R7 stack");
        wr_reg(3, 8'hFE);
        resolve(6, 0, 0, 0, 0, 0, 0, "R7 stack moved");
        resolve(7, 8'h44, 1, 0, 0, 0, 0, "R8 illegal mode");
        resolve(1, 8'h44, 1, 0, 0, 0, 0, "R8 err clears");
        resolve(2, 8'h9A, 0, 0, 0, 0, 1, "R10 stray start during indirect");
        resolve(4, 0, 1, 0, 0, 0, 1, "R9 R10 stray start during read");
        resolve(0, 8'h01, 0, 0, 0, 0, 0, "R10 back to back a");
        resolve(0, 8'h02, 0, 0, 0, 0, 0, "R10 back to back b");
        resolve(3, 0, 2, 1, 2, 8'hA5, 0, "R11 same-cycle write reads old");
        resolve(3, 0, 2, 0, 0, 0, 0, "R11 write visible after");
        resolve(5, 8'h10, 2, 0, 0, 0, 0, "R6 R11 displacement new reg");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule